// File: doc/BRIEF.md
# Phase-Qualified Processor Bus Access Unit

This block connects an 8-bit processor bus, in which every transfer is framed by the high phase of a bus clock, to registers inside a faster system-clock domain. The bus clock, the read/not-write line and the active-low chip select are passed through synchronizers. The unit then opens an access window only while the synchronized bus clock is high and the device is selected. From that window it derives active-low read and write strobes, an output enable for the data bus, a one-clock pulse when a write is captured, and a one-clock pulse when a read completes. Registers whose state changes when they are read can use the read-completion pulse.

A window counts only after it has been seen for at least `MIN_HIGH` system-clock samples, so narrow glitches have no effect. If the direction line drops from read to write while the window is open, the window is split into a read part and a write part. Each part is qualified on its own. If the select is withdrawn before the bus clock falls, the access is abandoned. Two target registers sit behind the unit so that it can be exercised alone: a direction register and a port register, chosen by one address bit.

Top module: `bus_phase_qualifier`

## Requirements
- R1: The write strobe `wr_n_o` is low only while a selected window is open with the direction line low, and the read strobe `rd_n_o` is low only while it is open with the direction line high. The two strobes are never low together.
- R2: With `sel_n_i` held high for a whole bus-clock high phase, no strobe is asserted, neither pulse is issued and no register changes.
- R3: The read strobe and `data_oe_o` go active exactly 3 system clocks after `phi2_i` rises, and they release exactly 3 system clocks after it falls. While `data_oe_o` is high, `data_o` shows the register chosen by `addr_i` (0 = direction register, 1 = port register). Otherwise `data_o` is zero.
- R4: A qualified write loads `data_i` into the register chosen by the address sampled at window start. It does so at the end of the window, in the same cycle that `wr_capture_o` is high for one clock.
- R5: A window seen for fewer than `MIN_HIGH` (default 2) synchronized samples produces neither `rd_commit_o` nor `wr_capture_o`, and it changes no register.
- R6: A qualified read produces exactly one `rd_commit_o` pulse, one clock long, when the window ends.
- R7: When the direction line falls from read to write inside an open window, the unit handles a read followed by a write. Each part issues its pulse only if that part alone lasted at least `MIN_HIGH` samples.
- R8: If the select is withdrawn while the bus clock is still high, the open part is abandoned. It issues no pulse and writes no register.
- R9: While `rst_n` is low, both registers read as zero, both strobes are high, `data_oe_o` is low and both pulses are low.
- R10: A register changes value only in a cycle in which `wr_capture_o` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phi2_i | input | 1 | Bus clock phase; transfers happen while high |
| rnw_i | input | 1 | Bus direction: 1 read, 0 write |
| sel_n_i | input | 1 | Active-low device select from the address decoder |
| addr_i | input | 1 | Register select: 0 direction, 1 port |
| data_i | input | DATA_W | Bus data toward the device |
| rd_n_o | output | 1 | Active-low read strobe |
| wr_n_o | output | 1 | Active-low write strobe |
| data_oe_o | output | 1 | Enable for driving the bus with read data |
| data_o | output | DATA_W | Read data, zero when not driving |
| wr_capture_o | output | 1 | One-clock pulse when write data is stored |
| rd_commit_o | output | 1 | One-clock pulse when a qualified read completes |
| dir_o | output | DATA_W | Direction register contents |
| port_o | output | DATA_W | Port register contents |

## Verification
Some properties are checked on every cycle: the strobes are mutually exclusive, each pulse lasts one clock and follows a strobe, the output enable releases after the synchronized bus clock falls, and the registers never change without a capture pulse. Other behaviour can only be shown by the bench's scenarios. These are the exact three-clock latency, the minimum window length, the independent qualification of the read and write parts of a split window, abandonment when the select is withdrawn, and which register a write lands in.

// File: rtl/bq_pkg.sv
package bq_pkg;
   typedef struct packed {
      logic phi;
      logic rnw;
      logic cs;
   } ctl_t;

   localparam int CTL_W = $bits(ctl_t);
   localparam ctl_t CTL_IDLE = '{phi: 1'b0, rnw: 1'b1, cs: 1'b0};
endpackage

// File: rtl/bq_sync.sv
module bq_sync #(
   parameter int             W       = 3,
   parameter int             STAGES  = 2,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (STAGES < 2) begin : g_bad_stages
         $error("bq_sync: STAGES must be at least 2");
      end
      if (W < 1) begin : g_bad_width
         $error("bq_sync: W must be positive");
      end
   endgenerate

   logic [W-1:0] st [STAGES];

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               st[g] <= RST_VAL;
            end else begin
               if (g == 0) st[g] <= d;
               else        st[g] <= st[(g == 0) ? 0 : g-1];
            end
         end
      end
   endgenerate

   assign q = st[STAGES-1];
endmodule

// File: rtl/bq_phase.sv
module bq_phase #(
   parameter int MIN_HIGH = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic phi_s,
   input  logic rnw_s,
   input  logic cs_s,
   input  logic addr_raw,
   output logic rd_n_o,
   output logic wr_n_o,
   output logic oe_o,
   output logic rd_commit_o,
   output logic wr_capture_o,
   output logic wr_fire_o,
   output logic addr_lat_o
);
   generate
      if (MIN_HIGH < 1) begin : g_bad_min
         $error("bq_phase: MIN_HIGH must be at least 1");
      end
   endgenerate

   localparam int               CNT_W   = (MIN_HIGH < 2) ? 1 : $clog2(MIN_HIGH + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_HIGH);

   logic             win, win_q, seg_rnw;
   logic [CNT_W-1:0] cnt;
   logic             seg_start, seg_end_ok, complete;

   assign win        = phi_s & cs_s;
   assign seg_start  = win && (!win_q || (rnw_s != seg_rnw));
   // a part ends cleanly on the phase fall or on a direction change; a select drop aborts it
   assign seg_end_ok = win_q && (!phi_s || (win && (rnw_s != seg_rnw)));
   assign complete   = seg_end_ok && (cnt == CNT_MAX);
   assign wr_fire_o  = complete && !seg_rnw;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         win_q        <= 1'b0;
         seg_rnw      <= 1'b1;
         cnt          <= '0;
         addr_lat_o   <= 1'b0;
         rd_n_o       <= 1'b1;
         wr_n_o       <= 1'b1;
         oe_o         <= 1'b0;
         rd_commit_o  <= 1'b0;
         wr_capture_o <= 1'b0;
      end else begin
         win_q <= win;
         if (seg_start) begin
            seg_rnw <= rnw_s;
            cnt     <= CNT_W'(1);
         end else if (win && (cnt != CNT_MAX)) begin
            cnt <= cnt + CNT_W'(1);
         end
         if (win && !win_q) addr_lat_o <= addr_raw;
         rd_n_o       <= !(win && rnw_s);
         wr_n_o       <= !(win && !rnw_s);
         oe_o         <= win && rnw_s;
         rd_commit_o  <= complete && seg_rnw;
         wr_capture_o <= complete && !seg_rnw;
      end
   end

   a_r1_strobes_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(!rd_n_o && !wr_n_o));
   a_r3_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(phi_s) |=> !oe_o);
   a_r6_commit_one_clock: assert property (@(posedge clk) disable iff (!rst_n)
      rd_commit_o |=> !rd_commit_o);
   a_r6_commit_after_read_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      rd_commit_o |-> $past(!rd_n_o));
   a_r4_capture_after_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      wr_capture_o |-> $past(!wr_n_o));
   a_r7_pulses_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(rd_commit_o && wr_capture_o));
endmodule

// File: rtl/bq_regs.sv
module bq_regs #(
   parameter int DATA_W    = 8,
   parameter bit ZERO_IDLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_fire,
   input  logic              sel,
   input  logic [DATA_W-1:0] wdata,
   input  logic              oe,
   output logic [DATA_W-1:0] rdata,
   output logic [DATA_W-1:0] dir_q,
   output logic [DATA_W-1:0] port_q
);
   generate
      if (DATA_W < 1) begin : g_bad_width
         $error("bq_regs: DATA_W must be positive");
      end
   endgenerate

   logic [DATA_W-1:0] mux;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dir_q  <= '0;
         port_q <= '0;
      end else if (wr_fire) begin
         if (sel) port_q <= wdata;
         else     dir_q  <= wdata;
      end
   end

   assign mux = sel ? port_q : dir_q;

   generate
      if (ZERO_IDLE) begin : g_zero_idle
         assign rdata = oe ? mux : '0;
      end else begin : g_pass
         assign rdata = mux;
      end
   endgenerate
endmodule

// File: rtl/bus_phase_qualifier.sv
module bus_phase_qualifier #(
   parameter int DATA_W      = 8,
   parameter int MIN_HIGH    = 2,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              phi2_i,
   input  logic              rnw_i,
   input  logic              sel_n_i,
   input  logic              addr_i,
   input  logic [DATA_W-1:0] data_i,
   output logic              rd_n_o,
   output logic              wr_n_o,
   output logic              data_oe_o,
   output logic [DATA_W-1:0] data_o,
   output logic              wr_capture_o,
   output logic              rd_commit_o,
   output logic [DATA_W-1:0] dir_o,
   output logic [DATA_W-1:0] port_o
);
   import bq_pkg::*;

   ctl_t ctl_raw, ctl_s;
   logic wr_fire, addr_lat;

   assign ctl_raw = '{phi: phi2_i, rnw: rnw_i, cs: ~sel_n_i};

   bq_sync #(
      .W       (CTL_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (CTL_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (ctl_raw),
      .q     (ctl_s)
   );

   bq_phase #(
      .MIN_HIGH (MIN_HIGH)
   ) u_phase (
      .clk          (clk),
      .rst_n        (rst_n),
      .phi_s        (ctl_s.phi),
      .rnw_s        (ctl_s.rnw),
      .cs_s         (ctl_s.cs),
      .addr_raw     (addr_i),
      .rd_n_o       (rd_n_o),
      .wr_n_o       (wr_n_o),
      .oe_o         (data_oe_o),
      .rd_commit_o  (rd_commit_o),
      .wr_capture_o (wr_capture_o),
      .wr_fire_o    (wr_fire),
      .addr_lat_o   (addr_lat)
   );

   bq_regs #(
      .DATA_W    (DATA_W),
      .ZERO_IDLE (1'b1)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_fire (wr_fire),
      .sel     (addr_lat),
      .wdata   (data_i),
      .oe      (data_oe_o),
      .rdata   (data_o),
      .dir_q   (dir_o),
      .port_q  (port_o)
   );

   a_r10_dir_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (dir_o != $past(dir_o)) |-> wr_capture_o);
   a_r10_port_needs_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (port_o != $past(port_o)) |-> wr_capture_o);
   a_r3_data_zero_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !data_oe_o |-> (data_o == '0));
endmodule

// File: tb/bus_phase_qualifier_tb.sv
module bus_phase_qualifier_tb;
   localparam int CLK_PERIOD = 10;
   localparam int DW = 8;

   typedef struct packed {
      logic [3:0] hi;
      logic [3:0] split;
      logic [3:0] abort;
      logic       rnw;
      logic       a;
      logic       seln;
      logic [7:0] d;
      logic [7:0] e_dir;
      logic [7:0] e_port;
      logic [7:0] e_last;
      logic [1:0] e_rd;
      logic [1:0] e_wr;
   } vec_t;

   localparam int NV = 12;
   localparam vec_t VEC [NV] = '{
      '{4'd4, 4'd0, 4'd0, 1'b0, 1'b0, 1'b0, 8'h5A, 8'h5A, 8'h00, 8'h00, 2'd0, 2'd1}, // R4 write dir
      '{4'd3, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 8'hC3, 8'h5A, 8'hC3, 8'h00, 2'd0, 2'd1}, // R4 write port
      '{4'd4, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A, 8'hC3, 8'h5A, 2'd1, 2'd0}, // R6 read dir
      '{4'd2, 4'd0, 4'd0, 1'b1, 1'b1, 1'b0, 8'h00, 8'h5A, 8'hC3, 8'hC3, 2'd1, 2'd0}, // R5 minimum length read
      '{4'd1, 4'd0, 4'd0, 1'b0, 1'b1, 1'b0, 8'hFF, 8'h5A, 8'hC3, 8'h00, 2'd0, 2'd0}, // R5 glitch write ignored
      '{4'd1, 4'd0, 4'd0, 1'b1, 1'b0, 1'b0, 8'h00, 8'h5A, 8'hC3, 8'h00, 2'd0, 2'd0}, // R5 glitch read ignored
      '{4'd4, 4'd0, 4'd0, 1'b0, 1'b0, 1'b1, 8'h11, 8'h5A, 8'hC3, 8'h00, 2'd0, 2'd0}, // R2 deselected
      '{4'd5, 4'd2, 4'd0, 1'b1, 1'b1, 1'b0, 8'h77, 8'h5A, 8'h77, 8'hC3, 2'd1, 2'd1}, // R7 both parts
      '{4'd4, 4'd1, 4'd0, 1'b1, 1'b0, 1'b0, 8'h3C, 8'h3C, 8'h77, 8'h00, 2'd0, 2'd1}, // R7 short read part
      '{4'd3, 4'd2, 4'd0, 1'b1, 1'b1, 1'b0, 8'h99, 8'h3C, 8'h77, 8'h77, 2'd1, 2'd0}, // R7 short write part
      '{4'd4, 4'd0, 4'd2, 1'b1, 1'b1, 1'b0, 8'h00, 8'h3C, 8'h77, 8'h00, 2'd0, 2'd0}, // R8 aborted read
      '{4'd4, 4'd0, 4'd2, 1'b0, 1'b0, 1'b0, 8'hEE, 8'h3C, 8'h77, 8'h00, 2'd0, 2'd0}  // R8 aborted write
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          phi2_i = 1'b0, rnw_i = 1'b1, sel_n_i = 1'b1, addr_i = 1'b0;
   logic [DW-1:0] data_i = '0;
   logic          rd_n_o, wr_n_o, data_oe_o, wr_capture_o, rd_commit_o;
   logic [DW-1:0] data_o, dir_o, port_o;

   int errors = 0, checks = 0;
   int rd_cnt = 0, wr_cnt = 0, both_cnt = 0;
   logic [DW-1:0] last_rd = '0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   bus_phase_qualifier u_dut (
      .clk (clk), .rst_n (rst_n), .phi2_i (phi2_i), .rnw_i (rnw_i),
      .sel_n_i (sel_n_i), .addr_i (addr_i), .data_i (data_i),
      .rd_n_o (rd_n_o), .wr_n_o (wr_n_o), .data_oe_o (data_oe_o),
      .data_o (data_o), .wr_capture_o (wr_capture_o), .rd_commit_o (rd_commit_o),
      .dir_o (dir_o), .port_o (port_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rd_commit_o) rd_cnt++;
         if (wr_capture_o) wr_cnt++;
         if (data_oe_o) last_rd = data_o;
         if (!rd_n_o && !wr_n_o) both_cnt++;
      end
   end

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic bus_cycle(int hi, int split, int abort, logic rnw, logic a,
                            logic seln, logic [7:0] d);
      @(negedge clk);
      rnw_i = rnw; addr_i = a; sel_n_i = seln; data_i = d;
      repeat (2) @(negedge clk);
      phi2_i = 1'b1;
      for (int i = 0; i < hi; i++) begin
         @(negedge clk);
         if (split != 0 && i + 1 == split) rnw_i = 1'b0;
         if (abort != 0 && i + 1 == abort) sel_n_i = 1'b1;
      end
      phi2_i = 1'b0;
      repeat (6) @(negedge clk);
      sel_n_i = 1'b1; rnw_i = 1'b1;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R9: reset state
      check("R9 rd_n", rd_n_o, 1);
      check("R9 wr_n", wr_n_o, 1);
      check("R9 oe", data_oe_o, 0);
      check("R9 pulses", {rd_commit_o, wr_capture_o}, 0);
      check("R9 dir", dir_o, 0);
      check("R9 port", port_o, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      for (int v = 0; v < NV; v++) begin
         rd_cnt = 0; wr_cnt = 0; last_rd = '0;
         bus_cycle(VEC[v].hi, VEC[v].split, VEC[v].abort, VEC[v].rnw,
                   VEC[v].a, VEC[v].seln, VEC[v].d);
         check($sformatf("R4 R10 dir vec%0d", v), dir_o, VEC[v].e_dir);
         check($sformatf("R4 R10 port vec%0d", v), port_o, VEC[v].e_port);
         check($sformatf("R6 read pulses vec%0d", v), rd_cnt, VEC[v].e_rd);
         check($sformatf("R4 write pulses vec%0d", v), wr_cnt, VEC[v].e_wr);
         if (VEC[v].e_rd != 0)
            check($sformatf("R3 read data vec%0d", v), last_rd, VEC[v].e_last);
      end

      // R3: exact strobe and enable timing on a port read (port holds 0x77)
      @(negedge clk);
      rnw_i = 1'b1; addr_i = 1'b1; sel_n_i = 1'b0;
      repeat (2) @(negedge clk);
      phi2_i = 1'b1;
      repeat (2) @(negedge clk);
      check("R3 rd_n before latency", rd_n_o, 1);
      @(negedge clk);
      check("R3 rd_n at latency", rd_n_o, 0);
      check("R3 oe at latency", data_oe_o, 1);
      check("R3 data driven", data_o, 8'h77);
      check("R1 no write strobe on read", wr_n_o, 1);
      @(negedge clk);
      phi2_i = 1'b0;
      repeat (2) @(negedge clk);
      check("R3 oe held before release", data_oe_o, 1);
      @(negedge clk);
      check("R3 oe released", data_oe_o, 0);
      check("R3 data zero after release", data_o, 0);
      repeat (4) @(negedge clk);
      sel_n_i = 1'b1;
      repeat (2) @(negedge clk);

      check("R1 strobes never both low", both_cnt, 0);

      // R9: reset during operation
      rst_n = 1'b0;
      @(negedge clk);
      check("R9 dir cleared", dir_o, 0);
      check("R9 port cleared", port_o, 0);
      check("R9 strobes idle", {rd_n_o, wr_n_o, data_oe_o}, 3'b110);
      rst_n = 1'b1;

      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end
endmodule